// File: doc/BRIEF.md
# Compare Pin Driver with Forced Match

This block owns the level of a single output-compare pin of a 16-bit timer. Each clock cycle it looks at two possible update sources: a compare-match pulse from the counter datapath, and a software force pulse. Either source is turned into one pin update. The update depends on a 2-bit action code that is present in the same cycle as the event.

The force pulse lets software produce a compare match on demand. It acts only when the timer is not in a PWM waveform mode, and it works through the same action code as a real match. The block keeps no record of the pulse. A force therefore has no effect outside its own cycle, and a read of the force control would always return zero. The block does not touch the counter or any interrupt flag.

Top module: `ocf_pin_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no event, the pin output is 0.
- R2: With action code 2'b00, an update event leaves the pin at its previous level.
- R3: With action code 2'b01, an update event inverts the pin. The new level appears at the clock edge that ends the event cycle.
- R4: With action code 2'b10, an update event drives the pin to 0 at the edge that ends the event cycle.
- R5: With action code 2'b11, an update event drives the pin to 1 at the edge that ends the event cycle.
- R6: When the PWM flag is low, a force pulse is an update event with the same timing and effect as a compare match.
- R7: When the PWM flag is high, a force pulse alone leaves the pin unchanged.
- R8: A force pulse is not held. In the cycles after the pulse, with no new event, the pin keeps its level.
- R9: A compare match and an accepted force in the same cycle cause one update only. With code 2'b01 the pin inverts once.
- R10: The action applied is the code present in the event cycle. A change to the code in a later cycle with no event does not alter the pin.
- R11: In a cycle with no compare match and no accepted force, the pin keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| match_evt | input | 1 | One-cycle compare-match pulse from the counter |
| force_req | input | 1 | One-cycle software force pulse |
| com_mode | input | 2 | Pin action: 00 hold, 01 invert, 10 low, 11 high |
| pwm_mode | input | 1 | High while the waveform mode is a PWM mode |
| pin_out | output | 1 | Compare pin level |

## Verification
The bench runs every combination of match, force, PWM flag and action code, once from a low pin and once from a high pin. It compares each result with a model that computes the pin arithmetically.

- Match-only cases separate the four actions.
- Force-only cases show whether the PWM flag gates the pulse.
- Cases with both sources show whether an invert is applied once or twice.
- Idle cycles that follow a strobe, some with a changed action code, would show any force that was held over or any code that was sampled late.

// File: rtl/ocf_pkg.sv
package ocf_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    ACT_HOLD   = 2'b00,
    ACT_INVERT = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } pin_act_e;

  // Next pin level for one update event under action code act.
  function automatic logic apply_act(input logic cur, input logic [MODE_W-1:0] act);
    logic res;
    case (pin_act_e'(act))
      ACT_HOLD:   res = cur;
      ACT_INVERT: res = ~cur;
      ACT_LOW:    res = 1'b0;
      default:    res = 1'b1;
    endcase
    return res;
  endfunction
endpackage

// File: rtl/ocf_event_merge.sv
module ocf_event_merge (
  input  logic match_evt,
  input  logic force_req,
  input  logic pwm_mode,
  output logic force_eff,
  output logic evt_fire
);
  // The force pulse is gated by the PWM flag and never registered.
  always_comb begin
    force_eff = force_req & ~pwm_mode;
    // Both sources merge into one event, so the pin updates at most once per cycle.
    evt_fire  = match_evt | force_eff;
  end
endmodule

// File: rtl/ocf_pin_reg.sv
module ocf_pin_reg #(
  parameter logic RST_LEVEL = 1'b0,
  parameter int   MODE_W    = ocf_pkg::MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_fire,
  input  logic [MODE_W-1:0] act,
  output logic              pin_next,
  output logic              pin_q
);
  always_comb begin
    pin_next = evt_fire ? ocf_pkg::apply_act(pin_q, act) : pin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= RST_LEVEL;
    else        pin_q <= pin_next;
  end
endmodule

// File: rtl/ocf_pin_unit.sv
module ocf_pin_unit #(
  parameter logic RST_LEVEL = 1'b0,
  parameter int   MODE_W    = ocf_pkg::MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              match_evt,
  input  logic              force_req,
  input  logic [MODE_W-1:0] com_mode,
  input  logic              pwm_mode,
  output logic              pin_out
);
  logic force_eff;
  logic evt_fire;
  logic pin_next;

  ocf_event_merge u_merge (
    .match_evt (match_evt),
    .force_req (force_req),
    .pwm_mode  (pwm_mode),
    .force_eff (force_eff),
    .evt_fire  (evt_fire)
  );

  ocf_pin_reg #(
    .RST_LEVEL (RST_LEVEL),
    .MODE_W    (MODE_W)
  ) u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_fire (evt_fire),
    .act      (com_mode),
    .pin_next (pin_next),
    .pin_q    (pin_out)
  );
endmodule

// File: rtl/ocf_pin_unit_chk.sv
module ocf_pin_unit_chk #(
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              match_evt,
  input logic              force_req,
  input logic [MODE_W-1:0] com_mode,
  input logic              pwm_mode,
  input logic              pin_out,
  input logic              force_eff,
  input logic              evt_fire
);
  logic upd;
  assign upd = match_evt | (force_req & ~pwm_mode);

  assert_hold_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd && com_mode == 2'b00 |=> $stable(pin_out));

  assert_invert_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd && com_mode == 2'b01 |=> pin_out != $past(pin_out));

  assert_low_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd && com_mode == 2'b10 |=> !pin_out);

  assert_high_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd && com_mode == 2'b11 |=> pin_out);

  assert_force_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    force_req && pwm_mode && !match_evt |=> $stable(pin_out));

  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_fire |=> $stable(pin_out));

  assert_force_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    force_eff |-> evt_fire);
endmodule

bind ocf_pin_unit ocf_pin_unit_chk #(.MODE_W(MODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .match_evt (match_evt),
  .force_req (force_req),
  .com_mode  (com_mode),
  .pwm_mode  (pwm_mode),
  .pin_out   (pin_out),
  .force_eff (force_eff),
  .evt_fire  (evt_fire)
);

// File: tb/tb_ocf_pin_unit.sv
`timescale 1ns/1ps
module tb_ocf_pin_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       match_evt = 1'b0;
  logic       force_req = 1'b0;
  logic [1:0] com_mode = 2'b00;
  logic       pwm_mode = 1'b0;
  logic       pin_out;

  int checks = 0;
  int errors = 0;
  logic model = 1'b0;

  always #4 clk = ~clk;

  ocf_pin_unit dut (
    .clk(clk), .rst_n(rst_n), .match_evt(match_evt), .force_req(force_req),
    .com_mode(com_mode), .pwm_mode(pwm_mode), .pin_out(pin_out)
  );

  // Bench model: the level after one event, computed from the action code bits.
  function automatic logic expect_level(input logic cur, input logic [1:0] m);
    if (m[1]) return m[0];
    return cur ^ m[0];
  endfunction

  task automatic check(input string req, input logic exp);
    checks++;
    if (pin_out !== exp) begin
      errors++;
      $display("FAIL %s pin_out=%0b expected=%0b", req, pin_out, exp);
    end
  endtask

  // Drive one cycle of inputs at the falling edge. Sample at the next falling edge.
  task automatic step(input logic m, input logic f, input logic [1:0] c, input logic p);
    match_evt = m; force_req = f; com_mode = c; pwm_mode = p;
    if (m || (f && !p)) model = expect_level(model, c);
    @(negedge clk);
    match_evt = 0; force_req = 0;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string tag;
    @(negedge clk);
    check("R1", 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0);
    @(negedge clk);
    check("R11", 1'b0);

    for (int start = 0; start < 2; start++) begin
      for (int combo = 0; combo < 32; combo++) begin
        logic m, f, p;
        logic [1:0] c;
        // Set the starting level with a plain match, code 11 for high or 10 for low.
        step(1'b1, 1'b0, start ? 2'b11 : 2'b10, 1'b0);
        m = combo[0]; f = combo[1]; p = combo[2]; c = combo[4:3];
        step(m, f, c, p);
        if (m && f && !p && c == 2'b01) tag = "R9";
        else if (!m && f && p) tag = "R7";
        else if (!m && f) tag = "R6";
        else if (!m) tag = "R11";
        else if (c == 2'b00) tag = "R2";
        else if (c == 2'b01) tag = "R3";
        else if (c == 2'b10) tag = "R4";
        else tag = "R5";
        check(tag, model);
        // No event now, and the code changes to high: the pin must not move.
        step(1'b0, 1'b0, 2'b11, p);
        check("R8", model);
        check("R10", model);
      end
    end

    // A force that inverts, followed by idle cycles that must not repeat the inversion.
    step(1'b1, 1'b0, 2'b10, 1'b0);
    step(1'b0, 1'b1, 2'b01, 1'b0);
    check("R6", 1'b1);
    step(1'b0, 1'b0, 2'b01, 1'b0);
    check("R8", 1'b1);
    step(1'b0, 1'b0, 2'b10, 1'b0);
    check("R10", 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule